// File: doc/BRIEF.md
# Ping-Pong Framebuffer Fetch Sequencer

This block streams a display frame out of memory into a local pixel FIFO. A frame lives in a framebuffer region given by a start address and an inclusive ceiling, the address of the region's last byte. The sequencer walks the region with read bursts over a request/grant/data handshake. In single mode it repeats buffer 0 on every frame. In dual mode it alternates between buffer 0 and buffer 1. When the last beat of a region has landed in the FIFO, it raises a sticky end-of-frame flag for that buffer.

Bursts have a programmable length that is encoded as a power of two. A burst is requested only when the FIFO has room for a whole burst, counting the beats already granted but not yet returned. The last burst of a frame is cut short so that no read goes past the ceiling. Returned words pass through a byte-ordering stage before they are written into the FIFO. The display side pops pixels and sees a "ready" level indication. If it pops an empty FIFO, a sticky underflow flag is set.

Software may rewrite a buffer's start and ceiling while the other buffer is being fetched. The values are captured only when the sequencer switches to that buffer.

Top module: `fb_fetch_seq`

## Requirements
- R1: After a synchronous active-low reset, `req_valid`, `pix_avail` and every `status` bit are 0.
- R2: With `run` high and the block idle, the next frame starts at buffer 0's start address. Each granted burst advances the address by its beat count times the beat size in bytes (4 by default).
- R3: `burst_code` values 0, 1, 2, 3 and 4 select bursts of 1, 2, 4, 8 and 16 beats. Codes 5 to 7 also select 16 beats.
- R4: A request is raised only while DEPTH minus the FIFO level minus the outstanding beats is at least the full programmed burst. The FIFO never holds more than DEPTH words.
- R5: When fewer beats than a full burst remain before the ceiling, the request asks for exactly the remaining beats. No requested beat lies above the ceiling.
- R6: With `dual_mode` low, every frame is fetched from buffer 0. Completing a frame sets `status[8]`, and `status[9]` is never set.
- R7: With `dual_mode` high, frames alternate 0, 1, 0, 1 and so on. Completing a buffer-1 frame sets `status[9]`.
- R8: A buffer's start and ceiling are sampled in the cycle the sequencer switches to it. Later changes affect only the next use of that buffer.
- R9: A raised request keeps its address and beat count unchanged until it is granted.
- R10: Returned data is reordered before storage. With `swap_bytes`, the two bytes of each 16-bit half are exchanged. With `big_endian`, the byte order of the whole (already swapped) word is reversed.
- R11: `pix_ready` is high exactly when the FIFO level is at least `rdy_thresh`.
- R12: A `pix_pop` while the FIFO is empty sets `status[5]` and removes nothing.
- R13: Status flags stay set until a one-cycle `stat_clr` pulse on the same bit clears them. A new event in the same cycle as a clear wins, and the flag stays set.
- R14: If `run` is low when a frame completes, the sequencer goes idle and raises no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep fetching frames |
| dual_mode | input | 1 | 0: buffer 0 only, 1: alternate buffers |
| burst_code | input | 3 | log2 of burst beat count |
| swap_bytes | input | 1 | Swap bytes within each 16-bit half |
| big_endian | input | 1 | Reverse byte order of the word |
| rdy_thresh | input | 8 | FIFO level for `pix_ready` |
| fb0_base | input | ADDR_W | Buffer 0 start address |
| fb0_ceil | input | ADDR_W | Buffer 0 last byte address |
| fb1_base | input | ADDR_W | Buffer 1 start address |
| fb1_ceil | input | ADDR_W | Buffer 1 last byte address |
| req_valid | output | 1 | Burst read request |
| req_addr | output | ADDR_W | Burst start address |
| req_beats | output | 5 | Beats in the burst |
| req_grant | input | 1 | Memory accepts the request |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DATA_W | Read data beat |
| pix_pop | input | 1 | Display removes one word |
| pix_data | output | DATA_W | Head word of the FIFO |
| pix_avail | output | 1 | FIFO not empty |
| pix_ready | output | 1 | FIFO level at or above threshold |
| status | output | 10 | Sticky flags: bit 9 end of buffer 1, bit 8 end of buffer 0, bit 5 underflow |
| stat_clr | input | 10 | One-cycle clear pulse per status bit |

## Verification
The bench checks a short final burst against a ceiling that is not a multiple of the burst. A design that rounds up would read past the region, and a design that stops early would lose the frame's last pixels. It rewrites buffer 1's pointers in the middle of a frame and keeps the FIFO close to full. A design that sampled the pointers continuously would jump region in the middle of a frame. A design that left in-flight beats out of the free-space sum would overfill the FIFO or issue a burst early. The bench also exercises burst codes above 4, both byte-ordering controls together, underflow at start-up, and a clear that lands in the same cycle as a flag event. Each of these would show a wrong beat count, a wrong data word or a wrong flag in the cycle-by-cycle comparison.

// File: rtl/fetch_pkg.sv
// Shared types and helpers for the framebuffer fetch sequencer.
// Assumes burst lengths are powers of two up to MAX_BURST beats.
package fetch_pkg;

    localparam int MAX_BURST = 16;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_state_t;

    // Decode the log2 burst code; codes above 4 clamp to the largest burst.
    function automatic logic [4:0] burst_beats(input logic [2:0] code);
        if (code >= 3'd4) begin
            return 5'd16;
        end
        return 5'd1 << code;
    endfunction

endpackage

// File: rtl/fetch_fifo.sv
// Pixel FIFO with first-word fall-through read port.
// Assumes DEPTH is a power of two. Writes are never issued when full
// (the sequencer reserves room). A read of an empty FIFO is ignored.
module fetch_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_rd;

    assign do_rd   = rd_en && (level != '0);
    assign rd_data = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp] <= wr_data;
        end
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_en) wp <= wp + AW'(1);
            if (do_rd) rp <= rp + AW'(1);
            level <= level + LVL_W'(wr_en) - LVL_W'(do_rd);
        end
    end
endmodule

// File: rtl/byte_lane_order.sv
// Combinational byte reordering of a fetched word.
// The halfword byte swap is applied first, then the optional full reversal.
// Assumes DATA_W is a multiple of 16.
module byte_lane_order #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic              swap_en,
    input  logic              rev_en,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] swapped;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        // Exchange the partner byte inside the 16-bit half.
        assign swapped[i*8 +: 8] = swap_en ? din[(i ^ 1)*8 +: 8] : din[i*8 +: 8];
        // Mirror the byte position across the word.
        assign dout[i*8 +: 8]    = rev_en ? swapped[(NB-1-i)*8 +: 8] : swapped[i*8 +: 8];
    end
endmodule

// File: rtl/fetch_sequencer.sv
// Frame address walker and burst issuer.
// It samples the selected buffer's start and ceiling when it switches to
// that buffer. It issues bursts only when a full burst fits in the free FIFO
// space, counting outstanding beats, and shortens the last burst at the
// ceiling. Assumes word-aligned start, ceil+1 word-aligned, ceil >= start,
// DEPTH >= MAX_BURST.
module fetch_sequencer
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int BYTES  = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dual_mode,
    input  logic [2:0]        burst_code,
    input  logic [ADDR_W-1:0] fb0_base,
    input  logic [ADDR_W-1:0] fb0_ceil,
    input  logic [ADDR_W-1:0] fb1_base,
    input  logic [ADDR_W-1:0] fb1_ceil,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              beat_done,
    input  logic              req_grant,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [4:0]        req_beats,
    output logic              eof0_set,
    output logic              eof1_set,
    output logic [LVL_W-1:0]  outstanding,
    output logic [ADDR_W-1:0] act_ceil
);
    localparam int BSH  = $clog2(BYTES);
    localparam int SP_W = LVL_W + 1;

    seq_state_t        st;
    logic              cur_buf;
    logic [ADDR_W-1:0] addr_q, ceil_q;
    logic [LVL_W-1:0]  outst_q;

    logic [4:0]        blen, len;
    logic [ADDR_W-1:0] rem_words;
    logic              is_last, space_ok, fire, drained, nxt_buf;
    logic [SP_W-1:0]   used;
    logic [ADDR_W-1:0] nxt_base, nxt_ceil;

    // Burst sizing, space check and next-buffer selection.
    always_comb begin
        blen      = burst_beats(burst_code);
        rem_words = ((ceil_q - addr_q) >> BSH) + ADDR_W'(1);
        is_last   = rem_words <= ADDR_W'(blen);
        len       = is_last ? rem_words[4:0] : blen;
        used      = SP_W'(fifo_level) + SP_W'(outst_q);
        space_ok  = (SP_W'(DEPTH) - used) >= SP_W'(blen);
        drained   = (st == SQ_DRAIN) && (outst_q == '0);
        nxt_buf   = (st == SQ_DRAIN) && dual_mode && !cur_buf;
        nxt_base  = nxt_buf ? fb1_base : fb0_base;
        nxt_ceil  = nxt_buf ? fb1_ceil : fb0_ceil;
    end

    assign req_valid   = (st == SQ_FETCH) && space_ok;
    assign req_addr    = addr_q;
    assign req_beats   = len;
    assign fire        = req_valid && req_grant;
    assign eof0_set    = drained && !cur_buf;
    assign eof1_set    = drained && cur_buf;
    assign outstanding = outst_q;
    assign act_ceil    = ceil_q;

    // Track beats granted but not yet written into the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_q + (fire ? LVL_W'(len) : '0) - LVL_W'(beat_done);
        end
    end

    // Frame state machine: load pointers, walk addresses, wait for drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            cur_buf <= 1'b0;
            addr_q  <= '0;
            ceil_q  <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (run) begin
                        st      <= SQ_FETCH;
                        cur_buf <= 1'b0;
                        addr_q  <= nxt_base;
                        ceil_q  <= nxt_ceil;
                    end
                end
                SQ_FETCH: begin
                    if (fire) begin
                        addr_q <= addr_q + (ADDR_W'(len) << BSH);
                        if (is_last) st <= SQ_DRAIN;
                    end
                end
                SQ_DRAIN: begin
                    if (drained) begin
                        if (run) begin
                            st      <= SQ_FETCH;
                            cur_buf <= nxt_buf;
                            addr_q  <= nxt_base;
                            ceil_q  <= nxt_ceil;
                        end else begin
                            st <= SQ_IDLE;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fb_fetch_seq.sv
// Top of the ping-pong framebuffer fetch sequencer.
// Joins the burst sequencer, the byte-order stage, the pixel FIFO and the
// sticky status flags (bit 9 end of buffer 1, bit 8 end of buffer 0,
// bit 5 underflow). Status set wins over a clear in the same cycle.
module fb_fetch_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dual_mode,
    input  logic [2:0]        burst_code,
    input  logic              swap_bytes,
    input  logic              big_endian,
    input  logic [7:0]        rdy_thresh,
    input  logic [ADDR_W-1:0] fb0_base,
    input  logic [ADDR_W-1:0] fb0_ceil,
    input  logic [ADDR_W-1:0] fb1_base,
    input  logic [ADDR_W-1:0] fb1_ceil,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [4:0]        req_beats,
    input  logic              req_grant,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              pix_pop,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_avail,
    output logic              pix_ready,
    output logic [9:0]        status,
    input  logic [9:0]        stat_clr
);
    localparam int BYTES    = DATA_W / 8;
    localparam int LVL_W    = $clog2(DEPTH + 1);
    localparam int CMP_W    = (LVL_W > 8) ? LVL_W : 8;
    localparam int ST_W     = 10;
    localparam int EOF0_BIT = 8;
    localparam int EOF1_BIT = 9;
    localparam int UFL_BIT  = 5;

    logic              eof0_set, eof1_set;
    logic [LVL_W-1:0]  fifo_lvl, seq_outst;
    logic [ADDR_W-1:0] seq_ceil;
    logic [DATA_W-1:0] ordered;
    logic [ST_W-1:0]   status_q, set_vec;

    fetch_sequencer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BYTES(BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .dual_mode(dual_mode),
        .burst_code(burst_code),
        .fb0_base(fb0_base), .fb0_ceil(fb0_ceil),
        .fb1_base(fb1_base), .fb1_ceil(fb1_ceil),
        .fifo_level(fifo_lvl), .beat_done(rd_valid), .req_grant(req_grant),
        .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats),
        .eof0_set(eof0_set), .eof1_set(eof1_set),
        .outstanding(seq_outst), .act_ceil(seq_ceil)
    );

    byte_lane_order #(.DATA_W(DATA_W)) u_order (
        .din(rd_data), .swap_en(swap_bytes), .rev_en(big_endian), .dout(ordered)
    );

    fetch_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(rd_valid), .wr_data(ordered),
        .rd_en(pix_pop), .rd_data(pix_data), .level(fifo_lvl)
    );

    assign pix_avail = (fifo_lvl != '0);
    assign pix_ready = CMP_W'(fifo_lvl) >= CMP_W'(rdy_thresh);
    assign status    = status_q;

    // Collect this cycle's flag events.
    always_comb begin
        set_vec           = '0;
        set_vec[EOF0_BIT] = eof0_set;
        set_vec[EOF1_BIT] = eof1_set;
        set_vec[UFL_BIT]  = pix_pop && (fifo_lvl == '0);
    end

    // Sticky flags: clear pulse first, then new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~stat_clr) | set_vec;
        end
    end
endmodule

// File: rtl/fb_fetch_seq_chk.sv
// Property checker for fb_fetch_seq, attached with bind.
// Observes the request port, the FIFO level and outstanding count, the
// active ceiling and the status flags.
module fb_fetch_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int BYTES  = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_grant,
    input logic [ADDR_W-1:0] req_addr,
    input logic [4:0]        req_beats,
    input logic [ADDR_W-1:0] act_ceil,
    input logic [LVL_W-1:0]  lvl,
    input logic [LVL_W-1:0]  outst,
    input logic              pix_pop,
    input logic              pix_avail,
    input logic [9:0]        status,
    input logic [9:0]        stat_clr
);
    localparam int BSH = $clog2(BYTES);

    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_grant |=> req_valid && $stable(req_addr) && $stable(req_beats));

    p_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_beats != 5'd0) && (req_beats <= 5'd16));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (LVL_W+1)'(lvl) + (LVL_W+1)'(outst) <= (LVL_W+1)'(DEPTH));

    p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr} + ((ADDR_W+1)'(req_beats) << BSH) - (ADDR_W+1)'(1))
                      <= {1'b0, act_ceil});

    p_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_pop && !pix_avail |=> status[5]);

    p_sticky_eof0_r13: assert property (@(posedge clk) disable iff (!rst_n)
        status[8] && !stat_clr[8] |=> status[8]);

    p_sticky_eof1_r13: assert property (@(posedge clk) disable iff (!rst_n)
        status[9] && !stat_clr[9] |=> status[9]);
endmodule

bind fb_fetch_seq fb_fetch_seq_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BYTES(BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
    .req_addr(req_addr), .req_beats(req_beats), .act_ceil(seq_ceil),
    .lvl(fifo_lvl), .outst(seq_outst), .pix_pop(pix_pop), .pix_avail(pix_avail),
    .status(status), .stat_clr(stat_clr)
);

// File: tb/sim_fb_fetch_seq.sv
// Bench for fb_fetch_seq: behavioural reference model compared every cycle,
// plus directed checks on mode, pointer, clamp, flag and stop behaviour.
module sim_fb_fetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int MAX_CYC    = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, dual_mode = 1'b0;
    logic [2:0]  burst_code = 3'd3;
    logic        swap_bytes = 1'b0, big_endian = 1'b0;
    logic [7:0]  rdy_thresh = 8'd8;
    logic [31:0] fb0_base = 32'h1000, fb0_ceil = 32'h104F;
    logic [31:0] fb1_base = 32'h8000, fb1_ceil = 32'h8093;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [4:0]  req_beats;
    logic        req_grant = 1'b0, rd_valid = 1'b0, pix_pop = 1'b0;
    logic [31:0] rd_data = '0;
    logic [31:0] pix_data;
    logic        pix_avail, pix_ready;
    logic [9:0]  status;
    logic [9:0]  stat_clr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_fetch_seq #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .dual_mode(dual_mode),
        .burst_code(burst_code), .swap_bytes(swap_bytes), .big_endian(big_endian),
        .rdy_thresh(rdy_thresh), .fb0_base(fb0_base), .fb0_ceil(fb0_ceil),
        .fb1_base(fb1_base), .fb1_ceil(fb1_ceil), .req_valid(req_valid),
        .req_addr(req_addr), .req_beats(req_beats), .req_grant(req_grant),
        .rd_valid(rd_valid), .rd_data(rd_data), .pix_pop(pix_pop),
        .pix_data(pix_data), .pix_avail(pix_avail), .pix_ready(pix_ready),
        .status(status), .stat_clr(stat_clr)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int          mst = 0;          // 0 idle, 1 fetching, 2 draining
    bit          mbuf = 1'b0;
    logic [31:0] m_addr = '0, m_ceil = '0;
    int          m_out = 0;
    logic [9:0]  m_stat = '0;
    logic [31:0] mq[$];
    logic [31:0] retq[$];

    // Stimulus controls.
    bit          pop_en = 1'b0;
    int          pop_den = 2;
    logic [9:0]  clr_v = '0;
    bit          prev_hold = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [4:0]  prev_beats = '0;
    bit          seen_new1 = 1'b0;
    int          max_beats = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1357_2468;
    endfunction

    // Expected byte ordering written byte by byte.
    function automatic logic [31:0] order(input logic [31:0] d, input bit sw, input bit be);
        logic [7:0] b [4];
        logic [7:0] t;
        for (int i = 0; i < 4; i++) b[i] = d[i*8 +: 8];
        if (sw) begin
            t = b[0]; b[0] = b[1]; b[1] = t;
            t = b[2]; b[2] = b[3]; b[3] = t;
        end
        if (be) begin
            t = b[0]; b[0] = b[3]; b[3] = t;
            t = b[1]; b[1] = b[2]; b[2] = t;
        end
        return {b[3], b[2], b[1], b[0]};
    endfunction

    // One clock: compare, drive handshake inputs, advance the model.
    task automatic cycle();
        int bl, rem, len, outp, sz;
        bit mreq, g, rv, pp;
        logic [31:0] rdv;
        logic [9:0] setv;
        #1;
        bl  = (burst_code >= 3'd4) ? 16 : (1 << burst_code);
        rem = int'((m_ceil - m_addr) >> 2) + 1;
        len = (rem < bl) ? rem : bl;
        sz  = mq.size();
        mreq = (mst == 1) && ((DEPTH - sz - m_out) >= bl);
        chk(req_valid == mreq, "R4 req_valid", {31'd0, req_valid}, {31'd0, mreq});
        if (mreq && req_valid) begin
            chk(req_addr == m_addr, "R2 req_addr", req_addr, m_addr);
            if (len < bl) chk(req_beats == 5'(len), "R5 short burst", {27'd0, req_beats}, len);
            else          chk(req_beats == 5'(len), "R3 burst beats", {27'd0, req_beats}, len);
            if (int'(req_beats) > max_beats) max_beats = int'(req_beats);
            if (mbuf && req_addr == 32'h9000) seen_new1 = 1'b1;
        end
        if (prev_hold)
            chk(req_valid && req_addr == prev_addr && req_beats == prev_beats, "R9 request hold",
                req_addr, prev_addr);
        chk(pix_avail == (sz > 0), "R4 pix_avail", {31'd0, pix_avail}, sz);
        if (sz > 0) chk(pix_data == mq[0], "R10 pix_data", pix_data, mq[0]);
        chk(pix_ready == (sz >= int'(rdy_thresh)), "R11 pix_ready", {31'd0, pix_ready}, sz);
        chk(status[8] == m_stat[8], "R6 eof0 flag", {22'd0, status}, {22'd0, m_stat});
        chk(status[9] == m_stat[9], "R7 eof1 flag", {22'd0, status}, {22'd0, m_stat});
        chk(status[5] == m_stat[5], "R12 underflow flag", {22'd0, status}, {22'd0, m_stat});
        chk(status == m_stat, "R13 status word", {22'd0, status}, {22'd0, m_stat});

        // Drive the handshake and display inputs for this edge.
        g  = req_valid && ($urandom_range(0, 2) != 0);
        rv = (retq.size() > 0) && ($urandom_range(0, 3) != 0);
        rdv = rv ? mk(retq[0]) : $urandom;
        if (rv) void'(retq.pop_front());
        pp = pop_en && ($urandom_range(0, pop_den - 1) == 0);
        req_grant = g;
        rd_valid  = rv;
        rd_data   = rdv;
        pix_pop   = pp;
        stat_clr  = clr_v;
        if (g) begin
            for (int i = 0; i < int'(req_beats); i++) retq.push_back(req_addr + 32'(4*i));
            chk(req_addr + 32'(4*int'(req_beats)) - 32'd1 <= m_ceil, "R5 ceiling", req_addr, m_ceil);
        end
        prev_hold  = req_valid && !g;
        prev_addr  = req_addr;
        prev_beats = req_beats;

        // Model step.
        setv = '0;
        outp = m_out;
        if (pp && sz == 0) setv[5] = 1'b1;
        if (pp && sz > 0) void'(mq.pop_front());
        if (rv) begin
            mq.push_back(order(rdv, swap_bytes, big_endian));
            m_out--;
        end
        case (mst)
            0: if (run) begin
                mst = 1; mbuf = 1'b0; m_addr = fb0_base; m_ceil = fb0_ceil;
            end
            1: if (mreq && g) begin
                m_out += len;
                m_addr += 32'(4*len);
                if (len == rem) mst = 2;
            end
            default: if (outp == 0) begin
                setv[mbuf ? 9 : 8] = 1'b1;
                if (run) begin
                    mbuf = dual_mode ? !mbuf : 1'b0;
                    m_addr = mbuf ? fb1_base : fb0_base;
                    m_ceil = mbuf ? fb1_ceil : fb0_ceil;
                    mst = 1;
                end else begin
                    mst = 0;
                end
            end
        endcase
        m_stat = (m_stat & ~clr_v) | setv;
        clr_v = '0;
        @(negedge clk);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(req_valid == 1'b0, "R1 reset req_valid", {31'd0, req_valid}, 0);
        chk(pix_avail == 1'b0, "R1 reset pix_avail", {31'd0, pix_avail}, 0);
        chk(status == 10'd0, "R1 reset status", {22'd0, status}, 0);
        rst_n = 1'b1;

        // Single mode, 8-beat bursts, 20-beat frame: last burst short (R5, R6).
        // Popping from the start drains an empty FIFO (R12).
        run = 1'b1; pop_en = 1'b1; pop_den = 2;
        cycles(500);
        chk(status[8] == 1'b1, "R6 eof0 seen", {22'd0, status}, 10'h100);
        chk(status[9] == 1'b0, "R6 no eof1 in single mode", {22'd0, status}, 0);
        chk(status[5] == 1'b1, "R12 underflow seen", {22'd0, status}, 10'h020);

        // Stop and go idle (R14), then clear flags (R13).
        run = 1'b0;
        cycles(200);
        pop_en = 1'b0;
        cycles(40);
        chk(mst == 0 && req_valid == 1'b0, "R14 idle after stop", {31'd0, req_valid}, 0);
        clr_v = 10'h320;
        cycles(1);
        chk(status == 10'd0, "R13 flags cleared", {22'd0, status}, 0);
        cycles(20);
        chk(status == 10'd0, "R13 cleared flags stay clear", {22'd0, status}, 0);

        // Dual mode, 16-beat bursts, byte swap; rewrite buffer 1 mid-frame (R7, R8).
        fb0_base = 32'h2000; fb0_ceil = 32'h2077;
        dual_mode = 1'b1; burst_code = 3'd4; swap_bytes = 1'b1;
        run = 1'b1; pop_en = 1'b1; pop_den = 2; rdy_thresh = 8'd12;
        cycles(60);
        fb1_base = 32'h9000; fb1_ceil = 32'h9023;
        cycles(1500);
        chk(status[9] == 1'b1, "R7 eof1 seen in dual mode", {22'd0, status}, 10'h200);
        chk(seen_new1 == 1'b1, "R8 new buffer-1 pointers used", {31'd0, seen_new1}, 1);

        // A clear landing together with events; model covers set-wins (R13).
        for (int k = 0; k < 30; k++) begin
            clr_v = 10'h320;
            cycles(7);
        end

        // Clamped code and big-endian, then both orderings (R3, R10).
        burst_code = 3'd6; swap_bytes = 1'b0; big_endian = 1'b1;
        pop_den = 1; rdy_thresh = 8'd20;
        cycles(800);
        chk(max_beats == 16, "R3 clamped code gives 16 beats", max_beats, 16);
        swap_bytes = 1'b1;
        cycles(800);

        // Single-beat bursts in single mode.
        dual_mode = 1'b0; burst_code = 3'd0; pop_den = 3; rdy_thresh = 8'd0;
        cycles(400);

        run = 1'b0;
        cycles(300);
        chk(mst == 0 && req_valid == 1'b0, "R14 final idle", {31'd0, req_valid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule